// File: doc/BRIEF.md
# Decimal Step Counter

The block holds one decimal digit and changes it once per rising clock edge. A two-bit step code chooses the action. The digit can stay where it is, go up by one, go up by two, or go down by one. The value always wraps inside 0 to 9, so stepping past either end comes back in on the other side.

Two outputs carry the same value. The digit appears as a four-bit binary number and as a seven-segment pattern ready to drive a single display. A synchronous, active-low reset returns the digit to zero.

Top module: `decade_stepper`

## Requirements
- R1: When `rst_n` is sampled low at a rising clock edge, `digit` reads 0 after that edge.
- R2: Step code 2'b00 leaves `digit` unchanged across the edge.
- R3: Step code 2'b01 adds one to `digit` at the edge, and 9 wraps to 0.
- R4: Step code 2'b10 adds two to `digit` at the edge, with 8 wrapping to 0 and 9 wrapping to 1.
- R5: Step code 2'b11 subtracts one from `digit` at the edge, and 0 wraps to 9.
- R6: `digit` never leaves the range 0 to 9 after reset, for any sequence of step codes.
- R7: `seg_n` is the active-low pattern of `digit`, with bit 6 as segment g down to bit 0 as segment a. The values for 0 to 9 are 40, 79, 24, 30, 19, 12, 02, 78, 00, 10 in hex. It follows `digit` in the same cycle.
- R8: Reset takes priority over any step code applied at the same edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| step_sel | input | 2 | Step code: 00 hold, 01 up one, 10 up two, 11 down one |
| digit | output | 4 | Current value, binary 0 to 9 |
| seg_n | output | 7 | Active-low seven-segment pattern, bit 6 = g ... bit 0 = a |

## Verification
Every step code and every reset takes effect at the single edge on which it is sampled. The new `digit` is therefore due one cycle after the stimulus, and `seg_n` is due in that same cycle because it is a combinational decode of the register. The bench applies each stimulus on a falling edge and reads both outputs on the next falling edge. That way the one register on the path has been crossed exactly once, and no read lands on a clock edge. Its expected values come from a modulo-ten sum and a glyph table held in the bench, not from the design.

// File: rtl/decade_stepper_pkg.sv
package decade_stepper_pkg;

  typedef enum logic [1:0] {
    STEP_HOLD  = 2'b00,
    STEP_UP1   = 2'b01,
    STEP_UP2   = 2'b10,
    STEP_DOWN1 = 2'b11
  } step_e;

  // Active-high glyphs, bit 6 = g ... bit 0 = a; hex letters cover unused codes
  function automatic logic [6:0] glyph_hi(input logic [3:0] v);
    logic [6:0] g;
    case (v)
      4'd0:  g = 7'b0111111;
      4'd1:  g = 7'b0000110;
      4'd2:  g = 7'b1011011;
      4'd3:  g = 7'b1001111;
      4'd4:  g = 7'b1100110;
      4'd5:  g = 7'b1101101;
      4'd6:  g = 7'b1111101;
      4'd7:  g = 7'b0000111;
      4'd8:  g = 7'b1111111;
      4'd9:  g = 7'b1101111;
      4'd10: g = 7'b1110111;
      4'd11: g = 7'b1111100;
      4'd12: g = 7'b0111001;
      4'd13: g = 7'b1011110;
      4'd14: g = 7'b1111001;
      default: g = 7'b1110001;
    endcase
    return g;
  endfunction

endpackage

// File: rtl/ds_step_unit.sv
module ds_step_unit
  import decade_stepper_pkg::*;
#(
  parameter int MODULUS = 10,
  localparam int W = $clog2(MODULUS)
) (
  input  logic [W-1:0] cur,
  input  step_e        sel,
  output logic [W-1:0] nxt,
  output logic         wrap_up,
  output logic         wrap_down
);

  localparam int SW = W + 1;

  // Every step becomes an upward offset below MODULUS; down-one is MODULUS-1
  function automatic logic [SW-1:0] step_offset(input step_e s);
    logic [SW-1:0] o;
    case (s)
      STEP_UP1:   o = SW'(1);
      STEP_UP2:   o = SW'(2);
      STEP_DOWN1: o = SW'(MODULUS - 1);
      default:    o = '0;
    endcase
    return o;
  endfunction

  // cur < MODULUS and offset < MODULUS, so one subtraction folds the sum
  function automatic logic [SW-1:0] fold(input logic [SW-1:0] s);
    return (s >= SW'(MODULUS)) ? s - SW'(MODULUS) : s;
  endfunction

  logic [SW-1:0] raw_sum;
  logic          over;

  always_comb begin
    raw_sum   = {1'b0, cur} + step_offset(sel);
    over      = raw_sum >= SW'(MODULUS);
    nxt       = W'(fold(raw_sum));
    wrap_up   = over && (sel != STEP_DOWN1);
    wrap_down = (sel == STEP_DOWN1) && !over;
  end

endmodule

// File: rtl/ds_count_reg.sv
module ds_count_reg #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  always_ff @(posedge clk) begin
    if (!rst_n) q <= '0;
    else        q <= d;
  end

endmodule

// File: rtl/ds_seg_encoder.sv
module ds_seg_encoder
  import decade_stepper_pkg::*;
#(
  parameter int  W          = 4,
  parameter bit  ACTIVE_LOW = 1'b1
) (
  input  logic [W-1:0] val,
  output logic [6:0]   seg
);

  logic [6:0] lit;
  always_comb lit = glyph_hi(4'(val));

  generate
    if (ACTIVE_LOW) begin : g_low
      assign seg = ~lit;
    end else begin : g_high
      assign seg = lit;
    end
  endgenerate

endmodule

// File: rtl/decade_stepper.sv
module decade_stepper
  import decade_stepper_pkg::*;
#(
  parameter int MODULUS = 10,
  localparam int W = $clog2(MODULUS)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [1:0]   step_sel,
  output logic [W-1:0] digit,
  output logic [6:0]   seg_n
);

  step_e        sel_e;
  logic [W-1:0] next_val;
  logic         wrap_up;
  logic         wrap_down;

  assign sel_e = step_e'(step_sel);

  ds_step_unit #(.MODULUS(MODULUS)) u_step (
    .cur       (digit),
    .sel       (sel_e),
    .nxt       (next_val),
    .wrap_up   (wrap_up),
    .wrap_down (wrap_down)
  );

  ds_count_reg #(.W(W)) u_reg (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (next_val),
    .q     (digit)
  );

  ds_seg_encoder #(.W(W), .ACTIVE_LOW(1'b1)) u_seg (
    .val (digit),
    .seg (seg_n)
  );

  AST_RESET_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rst_n) |-> digit == '0);  // R1
  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (step_sel == 2'b00) |=> $stable(digit));  // R2
  AST_UP1_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (step_sel == 2'b01) |=> digit == W'((32'($past(digit)) + 1) % MODULUS));  // R3
  AST_UP2_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (step_sel == 2'b10) |=> digit == W'((32'($past(digit)) + 2) % MODULUS));  // R4
  AST_WRAP_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_down |=> digit == W'(MODULUS - 1));  // R5
  AST_WRAP_UP_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_up |=> digit < W'(2));  // R3
  AST_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    digit < W'(MODULUS));  // R6
  AST_EIGHT_ALL_ON: assert property (@(posedge clk) disable iff (!rst_n)
    (digit == W'(8)) |-> seg_n == 7'h00);  // R7

endmodule

// File: tb/decade_stepper_tb_top.sv
module decade_stepper_tb_top;

  localparam int PERIOD = 10;
  localparam int NV = 20;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] step_sel = 2'b00;
  logic [3:0] digit;
  logic [6:0] seg_n;

  int checks = 0;
  int errors = 0;

  always #(PERIOD/2) clk = ~clk;

  decade_stepper dut_i (
    .clk(clk), .rst_n(rst_n), .step_sel(step_sel), .digit(digit), .seg_n(seg_n)
  );

  // {rst_n, step_sel, expected digit}
  localparam logic [6:0] VEC [NV] = '{
    {1'b1, 2'b01, 4'd1}, {1'b1, 2'b01, 4'd2}, {1'b1, 2'b10, 4'd4},
    {1'b1, 2'b10, 4'd6}, {1'b1, 2'b10, 4'd8}, {1'b1, 2'b10, 4'd0},
    {1'b1, 2'b11, 4'd9}, {1'b1, 2'b01, 4'd0}, {1'b1, 2'b11, 4'd9},
    {1'b1, 2'b10, 4'd1}, {1'b1, 2'b00, 4'd1}, {1'b1, 2'b00, 4'd1},
    {1'b1, 2'b11, 4'd0}, {1'b1, 2'b11, 4'd9}, {1'b1, 2'b01, 4'd0},
    {1'b1, 2'b01, 4'd1}, {1'b1, 2'b11, 4'd0}, {1'b1, 2'b10, 4'd2},
    {1'b0, 2'b10, 4'd0}, {1'b1, 2'b11, 4'd9}
  };

  // Expected segments, active low: lit segments are 0
  function automatic logic [6:0] exp_seg(input int v);
    logic [6:0] on [10] = '{7'h3F, 7'h06, 7'h5B, 7'h4F, 7'h66,
                            7'h6D, 7'h7D, 7'h07, 7'h7F, 7'h6F};
    return ~on[v];
  endfunction

  function automatic string tag_of(input logic r, input logic [1:0] s);
    if (!r) return "R8";
    case (s)
      2'b00:   return "R2";
      2'b01:   return "R3";
      2'b10:   return "R4";
      default: return "R5";
    endcase
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic apply(input logic r, input logic [1:0] s);
    rst_n = r;
    step_sel = s;
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #(PERIOD * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int model;
    @(negedge clk);
    apply(1'b0, 2'b01);
    apply(1'b0, 2'b10);
    check("R1", digit, 0);
    check("R7", seg_n, 7'h40);

    for (int i = 0; i < NV; i++) begin
      apply(VEC[i][6], VEC[i][5:4]);
      check(tag_of(VEC[i][6], VEC[i][5:4]), digit, VEC[i][3:0]);
      check("R7", seg_n, exp_seg(int'(VEC[i][3:0])));
    end

    // Directed: reset while digit non-zero, then a long mixed sweep
    apply(1'b1, 2'b10);
    apply(1'b1, 2'b10);
    apply(1'b0, 2'b11);
    check("R1", digit, 0);
    model = 0;
    for (int i = 0; i < 60; i++) begin
      logic [1:0] s;
      int off;
      s = 2'((i * 7 + (i >> 3)) & 3);
      case (s)
        2'b00: off = 0;
        2'b01: off = 1;
        2'b10: off = 2;
        default: off = 9;
      endcase
      model = (model + off) % 10;
      apply(1'b1, s);
      check("R6", int'(digit < 4'd10), 1);
      check(tag_of(1'b1, s), digit, model);
      check("R7", seg_n, exp_seg(model));
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule